// File: doc/BRIEF.md
# Reference Frequency Monitor

This block watches a single reference clock from the domain of a free-running master clock. The reference is brought in through a two-stage synchronizer, and its rising edges are counted. On its own, the block decides which of seven standard telecom rates the reference runs at, from 2 kHz up to 19.44 MHz. Nothing tells it which rate to expect. It reports that rate as a small code, together with a valid flag.

Once the rate is known, the block checks whether the measured frequency lies within a tolerance window around the nominal value. The window is given in parts per million. The out-of-range flag has hysteresis: it sets above an upper offset and clears only below a lower offset. A single input pin selects one of two limit pairs. If the reference stops, a timeout marks it as absent.

Each measurement spans a whole number of reference periods and lasts at least `WIN_CYC` master cycles. The block compares the master-cycle count against the edge count multiplied by precomputed fixed-point nominal periods. This needs no division in hardware. The parameter `TOL_DENOM` sets what one part of the offset means. Its default is one million, so the limits are in ppm.

Top module: `freq_ref_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, `freq_code_o` is 7, `ref_valid_o` is 0 and `out_of_range_o` is 1.
- R2: A reference whose frequency is within 6.25 % of a table rate is reported with that rate's code. The codes are 0 = 2 kHz, 1 = 8 kHz, 2 = 1.544 MHz, 3 = 2.048 MHz, 4 = 8.192 MHz, 5 = 16.384 MHz and 6 = 19.44 MHz. No input names the expected rate.
- R3: A toggling reference that matches no table rate gives `freq_code_o` = 7 with `out_of_range_o` = 1.
- R4: `ref_valid_o` is 1 exactly when `freq_code_o` is in the range 0 to 6.
- R5: With `wide_lim_i` = 0, the out-of-range flag sets when the offset exceeds 52 parts per `TOL_DENOM`. It clears when the offset is below 40 parts.
- R6: With `wide_lim_i` = 1, the flag sets above 83 parts and clears below 64 parts.
- R7: An offset between the selected lower and upper limits leaves the out-of-range flag unchanged.
- R8: If no reference rising edge is seen for `TIMEOUT_CYC` master cycles, the code becomes 7, valid drops and the out-of-range flag sets. Before that time, the previous result is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Monitored reference, asynchronous to clk |
| wide_lim_i | input | 1 | Limit pair select: 0 = 40/52, 1 = 64/83 parts |
| freq_code_o | output | 3 | Detected rate code, 7 = none |
| ref_valid_o | output | 1 | Reference matches a table rate |
| out_of_range_o | output | 1 | Frequency offset flag with hysteresis |

## Verification
The hardest state to reach from the ports is the hysteresis band. To show that the flag holds there, the reference must first be driven to one side of the band and then brought back into it. The flag must then be observed to keep whichever value it had before. The bench builds the design with a reduced `TOL_DENOM`, so that a window of a few thousand cycles resolves percent-level offsets. It then steps a real-valued reference period through the sequence below, above, between, with both limit pairs. The timeout is checked both shortly before and shortly after it expires.

// File: rtl/freq_mon_pkg.sv
package freq_mon_pkg;

    localparam int NCODES = 7;
    localparam int FRAC   = 20;

    typedef logic [2:0] fcode_t;
    localparam fcode_t CODE_NONE = 3'd7;

    localparam longint unsigned NARROW_LO = 40;
    localparam longint unsigned NARROW_HI = 52;
    localparam longint unsigned WIDE_LO   = 64;
    localparam longint unsigned WIDE_HI   = 83;

    typedef struct packed {
        fcode_t code;
        logic   in_table;
        logic   over_hi;
        logic   under_lo;
    } verdict_t;

    function automatic longint unsigned nominal_hz(input int idx);
        case (idx)
            0:       return 64'd2000;
            1:       return 64'd8000;
            2:       return 64'd1544000;
            3:       return 64'd2048000;
            4:       return 64'd8192000;
            5:       return 64'd16384000;
            default: return 64'd19440000;
        endcase
    endfunction

    // nominal period in master cycles, FRAC fraction bits
    function automatic longint unsigned per_q(input longint unsigned mclk, input int idx);
        longint unsigned hz;
        hz = nominal_hz(idx);
        return ((mclk << FRAC) + hz / 2) / hz;
    endfunction

    // per-edge tolerance of a limit, same fixed-point scale as per_q
    function automatic longint unsigned tol_q(input longint unsigned mclk, input int idx,
                                              input longint unsigned parts,
                                              input longint unsigned denom);
        longint unsigned d;
        d = nominal_hz(idx) * denom;
        return ((mclk << FRAC) * parts + d / 2) / d;
    endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [1:0] sync_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], async_i};
            prev_q <= sync_q[1];
        end
    end

    assign rise_o = sync_q[1] & ~prev_q;

    // R2: an edge is reported as a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fm_period_meter.sv
module fm_period_meter #(
    parameter int WIN_CYC     = 1048576,
    parameter int TIMEOUT_CYC = 50000,
    parameter int CW          = 22,
    localparam int TW         = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    output logic          done_o,
    output logic [CW-1:0] cyc_o,
    output logic [CW-1:0] edg_o,
    output logic          lost_o
);
    localparam logic [CW-1:0] WIN_L = CW'(WIN_CYC);
    localparam logic [TW-1:0] TMO_L = TW'(TIMEOUT_CYC);

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ecnt_q;
    logic [TW-1:0] idle_q;

    always_ff @(posedge clk) begin
        done_o <= 1'b0;
        lost_o <= 1'b0;
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            ecnt_q  <= '0;
            idle_q  <= '0;
            cyc_o   <= '0;
            edg_o   <= '0;
        end else if (rise_i) begin
            idle_q <= '0;
            if (!armed_q) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
                ecnt_q  <= '0;
            end else if (cnt_q + CW'(1) >= WIN_L) begin
                done_o <= 1'b1;
                cyc_o  <= cnt_q + CW'(1);
                edg_o  <= ecnt_q + CW'(1);
                cnt_q  <= '0;
                ecnt_q <= '0;
            end else begin
                cnt_q  <= cnt_q + CW'(1);
                ecnt_q <= ecnt_q + CW'(1);
            end
        end else begin
            if (armed_q)
                cnt_q <= cnt_q + CW'(1);
            if (idle_q != TMO_L)
                idle_q <= idle_q + TW'(1);
            if (idle_q == TMO_L - TW'(1)) begin
                lost_o  <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    // R2: a finished window always spans at least WIN_CYC cycles
    a_r2_window_min: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cyc_o >= WIN_L && edg_o != '0));

    // R8: the silence counter saturates at the timeout
    a_r8_idle_bound: assert property (@(posedge clk) disable iff (rst)
        idle_q <= TMO_L);

endmodule

// File: rtl/fm_classifier.sv
module fm_classifier
    import freq_mon_pkg::*;
#(
    parameter int MCLK_HZ   = 50000000,
    parameter int TOL_DENOM = 1000000,
    parameter int CW        = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done_i,
    input  logic [CW-1:0] cyc_i,
    input  logic [CW-1:0] edg_i,
    input  logic          lost_i,
    input  logic          wide_i,
    output fcode_t        code_o,
    output logic          valid_o,
    output logic          oor_o
);
    localparam longint unsigned MCLK = longint'(MCLK_HZ);
    localparam longint unsigned DEN  = longint'(TOL_DENOM);
    localparam int PW = $clog2(per_q(MCLK, 0) + 1) + 1;
    localparam int XW = CW + PW;

    logic [XW-1:0]     cyc_x, edg_x, meas;
    logic [NCODES-1:0] match, hi, lo;
    verdict_t          v;

    assign cyc_x = XW'(cyc_i);
    assign edg_x = XW'(edg_i);
    assign meas  = cyc_x << FRAC;

    for (genvar h = 0; h < NCODES; h++) begin : g_rate
        localparam longint unsigned PQ  = per_q(MCLK, h);
        localparam longint unsigned N_L = tol_q(MCLK, h, NARROW_LO, DEN);
        localparam longint unsigned N_H = tol_q(MCLK, h, NARROW_HI, DEN);
        localparam longint unsigned W_L = tol_q(MCLK, h, WIDE_LO, DEN);
        localparam longint unsigned W_H = tol_q(MCLK, h, WIDE_HI, DEN);

        logic [XW-1:0] expv, dev, thr_lo, thr_hi;

        assign expv   = edg_x * XW'(PQ);
        assign dev    = (meas > expv) ? meas - expv : expv - meas;
        assign thr_lo = edg_x * (wide_i ? XW'(W_L) : XW'(N_L));
        assign thr_hi = edg_x * (wide_i ? XW'(W_H) : XW'(N_H));
        assign match[h] = dev < (expv >> 4);
        assign hi[h]    = dev > thr_hi;
        assign lo[h]    = dev < thr_lo;
    end

    always_comb begin
        v = '{code: CODE_NONE, in_table: 1'b0, over_hi: 1'b0, under_lo: 1'b0};
        for (int h = 0; h < NCODES; h++) begin
            if (match[h]) begin
                v.code     = fcode_t'(h);
                v.in_table = 1'b1;
                v.over_hi  = hi[h];
                v.under_lo = lo[h];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || lost_i) begin
            code_o  <= CODE_NONE;
            valid_o <= 1'b0;
            oor_o   <= 1'b1;
        end else if (done_i) begin
            code_o  <= v.code;
            valid_o <= v.in_table;
            if (!v.in_table || v.over_hi)
                oor_o <= 1'b1;
            else if (v.under_lo)
                oor_o <= 1'b0;
        end
    end

    // R3: no table match always carries the out-of-range flag
    a_r3_none_is_oor: assert property (@(posedge clk) disable iff (rst)
        (code_o == CODE_NONE) |-> oor_o);

    // R7: a matched result inside the band keeps the flag
    a_r7_band_holds: assert property (@(posedge clk) disable iff (rst)
        (done_i && !lost_i && v.in_table && !v.over_hi && !v.under_lo) |=> $stable(oor_o));

    // R8: a timeout forces the absent result
    a_r8_lost_clears: assert property (@(posedge clk) disable iff (rst)
        lost_i |=> (code_o == CODE_NONE && !valid_o && oor_o));

endmodule

// File: rtl/freq_ref_monitor.sv
module freq_ref_monitor
    import freq_mon_pkg::*;
#(
    parameter int MCLK_HZ     = 50000000,
    parameter int WIN_CYC     = 1048576,
    parameter int TIMEOUT_CYC = 2 * (MCLK_HZ / 2000),
    parameter int TOL_DENOM   = 1000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_clk_i,
    input  logic       wide_lim_i,
    output logic [2:0] freq_code_o,
    output logic       ref_valid_o,
    output logic       out_of_range_o
);
    localparam int CW = $clog2(WIN_CYC + TIMEOUT_CYC + 2) + 1;

    logic          rise;
    logic          done, lost;
    logic [CW-1:0] cyc, edg;
    fcode_t        code;

    fm_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ref_clk_i),
        .rise_o  (rise)
    );

    fm_period_meter #(
        .WIN_CYC     (WIN_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CW          (CW)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise),
        .done_o (done),
        .cyc_o  (cyc),
        .edg_o  (edg),
        .lost_o (lost)
    );

    fm_classifier #(
        .MCLK_HZ   (MCLK_HZ),
        .TOL_DENOM (TOL_DENOM),
        .CW        (CW)
    ) u_class (
        .clk     (clk),
        .rst     (rst),
        .done_i  (done),
        .cyc_i   (cyc),
        .edg_i   (edg),
        .lost_i  (lost),
        .wide_i  (wide_lim_i),
        .code_o  (code),
        .valid_o (ref_valid_o),
        .oor_o   (out_of_range_o)
    );

    assign freq_code_o = code;

    // R4: valid and a table code go together
    a_r4_valid_code: assert property (@(posedge clk) disable iff (rst)
        ref_valid_o == (freq_code_o != CODE_NONE));

endmodule

// File: tb/freq_ref_monitor_test.sv
`timescale 1ns/1ps
module freq_ref_monitor_test;

    localparam int  WIN  = 4000;
    localparam int  TMO  = 12000;
    localparam int  DEN  = 2000;
    localparam real MHZ  = 50.0e6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk = 1'b0;
    logic       wide = 1'b0;
    logic [2:0] code;
    logic       valid, oor;

    int  total = 0;
    int  bad   = 0;
    bit  ref_on = 1'b0;
    bit  finished = 1'b0;
    real f_cur = 2048000.0;
    real nom [7] = '{2000.0, 8000.0, 1544000.0, 2048000.0, 8192000.0, 16384000.0, 19440000.0};

    freq_ref_monitor #(
        .MCLK_HZ     (50000000),
        .WIN_CYC     (WIN),
        .TIMEOUT_CYC (TMO),
        .TOL_DENOM   (DEN)
    ) uut (
        .clk            (clk),
        .rst            (rst),
        .ref_clk_i      (ref_clk),
        .wide_lim_i     (wide),
        .freq_code_o    (code),
        .ref_valid_o    (valid),
        .out_of_range_o (oor)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            if (ref_on) begin
                ref_clk = 1'b1;
                #(1.0e9 / (2.0 * f_cur));
                ref_clk = 1'b0;
                #(1.0e9 / (2.0 * f_cur));
            end else begin
                ref_clk = 1'b0;
                #20;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // offset in parts per DEN; waits two full windows after the change
    task automatic drive(input real f_nom, input int parts);
        f_cur  = f_nom * (1.0 + real'(parts) / real'(DEN));
        ref_on = 1'b1;
        cycles(2 * (WIN + int'(MHZ / f_cur) + 1) + 100);
    endtask

    task automatic t_reset();
        cycles(1);
        chk("R1 code", code, 7);
        chk("R1 valid", valid, 0);
        chk("R1 oor", oor, 1);
    endtask

    task automatic t_sweep();
        for (int c = 1; c < 7; c++) begin
            drive(nom[c], 0);
            chk($sformatf("R2 code for rate %0d", c), code, c);
            chk("R4 valid on match", valid, 1);
            chk("R5 nominal clears oor", oor, 0);
        end
    endtask

    task automatic t_unknown();
        drive(5.0e6, 0);
        chk("R3 code none", code, 7);
        chk("R3 oor on none", oor, 1);
        chk("R4 valid low on none", valid, 0);
    endtask

    task automatic t_narrow();
        wide = 1'b0;
        drive(nom[3], 0);
        chk("R5 in range", oor, 0);
        drive(nom[3], 44);
        chk("R7 band keeps clear", oor, 0);
        chk("R2 code kept with offset", code, 3);
        drive(nom[3], 60);
        chk("R5 above 52 sets", oor, 1);
        drive(nom[3], 44);
        chk("R7 band keeps set", oor, 1);
        drive(nom[3], 20);
        chk("R5 below 40 clears", oor, 0);
    endtask

    task automatic t_wide();
        wide = 1'b1;
        drive(nom[6], 0);
        chk("R6 in range", oor, 0);
        drive(nom[6], 72);
        chk("R6 band holds clear", oor, 0);
        drive(nom[6], 88);
        chk("R6 above 83 sets", oor, 1);
        chk("R2 code at 88 parts", code, 6);
        drive(nom[6], 58);
        chk("R6 below 64 clears", oor, 0);
        wide = 1'b0;
    endtask

    task automatic t_timeout();
        ref_on = 1'b0;
        cycles(TMO - 1500);
        chk("R8 held before timeout", code, 6);
        chk("R8 valid held", valid, 1);
        cycles(1700);
        chk("R8 code after timeout", code, 7);
        chk("R8 valid after timeout", valid, 0);
        chk("R8 oor after timeout", oor, 1);
    endtask

    initial begin
        cycles(5);
        chk("R1 code in reset", code, 7);
        chk("R1 oor in reset", oor, 1);
        rst = 1'b0;
        t_reset();
        t_sweep();
        t_unknown();
        t_narrow();
        t_wide();
        t_timeout();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=195000 cycles expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule